// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block stores the configuration of a small, parameterised set of address-match debug triggers. Software reaches it through a simple register port. One index register picks the trigger. The configuration and comparison-value registers then act on that trigger only. A fourth, auxiliary register is reserved and always reads zero. Reads are combinational. Writes commit on the rising clock edge when the write strobe is high.

A trigger can be claimed by debug mode through a flag in its configuration word. While the core is outside debug mode, such a trigger cannot be changed. Three summary outputs report whether any trigger has fetch, load or store matching enabled. The fetch, load and store paths of the core use them to decide whether they need to compare addresses at all. The comparison, chaining and firing actions are handled elsewhere.

Top module: `trig_bank`

## Requirements
- R1: A write to the index register (register code 0) is accepted only when the written value is below NUM_TRIG. Any larger value, including values with upper bits set, leaves the previous index in place. Reading code 0 returns the index, zero-extended.
- R2: After reset the index is 0. Every trigger's configuration word reads with bits [XLEN-1:XLEN-4] equal to 2 and all other bits 0. Every comparison value reads 0. All three summary outputs are low.
- R3: A configuration write (register code 1) to an unlocked trigger stores the following fields, and a read returns them in the same positions. The debug-owned flag is at bit XLEN-5. The select bit is at 19, timing at 18, action at [17:12], chain at 11, match at [10:7], and the privilege enables at 6 (m), 5 (h), 4 (s) and 3 (u). Execute is at 2, store at 1 and load at 0. Bits [XLEN-6:XLEN-11] (mask limit) and bit 20 read 0. The type field cannot be written.
- R4: When a configuration write sets the execute enable (bit 2), the stored timing bit becomes 0 whatever value was written.
- R5: While the selected trigger's debug-owned flag is set and dbg_mode_i is low, writes to its configuration (code 1) and comparison value (code 2) are ignored.
- R6: While dbg_mode_i is high, a debug-owned trigger accepts configuration and comparison-value writes, including a write that clears the debug-owned flag.
- R7: The comparison value (register code 2) is a full XLEN-bit register kept separately for each trigger. Writes and reads reach only the trigger chosen by the index.
- R8: The auxiliary register (code 3) always reads 0. A write to it changes no other register and no output.
- R9: watch_exec_o, watch_load_o and watch_store_o are the OR, across all triggers, of the execute, load and store enables. They reflect a configuration write from the clock edge that commits it.
- R10: With wr_en_i low, no stored state changes whatever the other inputs do. rd_data_o follows reg_sel_i and the index without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dbg_mode_i | input | 1 | Core is in debug mode |
| reg_sel_i | input | 2 | Register code: 0 index, 1 configuration, 2 comparison value, 3 auxiliary |
| wr_en_i | input | 1 | Write strobe, commits on the rising edge |
| wr_data_i | input | XLEN | Write data |
| rd_data_o | output | XLEN | Combinational read data |
| watch_exec_o | output | 1 | Some trigger has execute matching enabled |
| watch_load_o | output | 1 | Some trigger has load matching enabled |
| watch_store_o | output | 1 | Some trigger has store matching enabled |

## Verification
A corrupted configuration field or comparison value stays hidden until software reads that trigger back. At that read it shows up on rd_data_o in the same cycle, so the bench reads every register of every trigger after each phase. A wrong enable bit shows on the summary outputs in the cycle after the faulty write. Those outputs are therefore compared with the bench's model on every clock. A broken lock or index guard appears as a read-back value that differs from the model on the next read.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    REG_INDEX = 2'd0,
    REG_CFG   = 2'd1,
    REG_VALUE = 2'd2,
    REG_AUX   = 2'd3
  } reg_id_e;

  localparam int unsigned TYPE_W     = 4;
  localparam int unsigned MASKMAX_W  = 6;
  localparam logic [TYPE_W-1:0] TYPE_ADDR_DATA = 4'd2;

  localparam int unsigned F_LOAD   = 0;
  localparam int unsigned F_STORE  = 1;
  localparam int unsigned F_EXEC   = 2;
  localparam int unsigned F_U      = 3;
  localparam int unsigned F_S      = 4;
  localparam int unsigned F_H      = 5;
  localparam int unsigned F_M      = 6;
  localparam int unsigned F_MATCH  = 7;
  localparam int unsigned MATCH_W  = 4;
  localparam int unsigned F_CHAIN  = 11;
  localparam int unsigned F_ACTION = 12;
  localparam int unsigned ACTION_W = 6;
  localparam int unsigned F_TIMING = 18;
  localparam int unsigned F_SELECT = 19;

  typedef struct packed {
    logic                dmode;
    logic                sel;
    logic                timing;
    logic [ACTION_W-1:0] action;
    logic                chain;
    logic [MATCH_W-1:0]  match;
    logic                m;
    logic                h;
    logic                s;
    logic                u;
    logic                exec;
    logic                store;
    logic                load;
  } trig_cfg_t;

endpackage

// File: rtl/trig_sel_reg.sv
module trig_sel_reg #(
  parameter int unsigned NUM_TRIG = 4,
  parameter int unsigned XLEN     = 32,
  localparam int unsigned SEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [XLEN-1:0]  wdata_i,
  output logic [SEL_W-1:0] sel_o
);

  localparam logic [XLEN-1:0]  LIMIT     = XLEN'(NUM_TRIG);
  localparam logic [SEL_W:0]   LIMIT_SEL = (SEL_W+1)'(NUM_TRIG);

  logic [SEL_W-1:0] sel_q;
  logic             accept;

  assign accept = wdata_i < LIMIT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               sel_q <= '0;
    else if (we_i && accept)   sel_q <= wdata_i[SEL_W-1:0];
  end

  assign sel_o = sel_q;

  p_sel_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !accept) |=> $stable(sel_q));

  p_sel_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, sel_q} < LIMIT_SEL);

endmodule

// File: rtl/trig_entry.sv
module trig_entry
  import trig_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dbg_mode_i,
  input  logic            cfg_we_i,
  input  logic            val_we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] cfg_rd_o,
  output logic [XLEN-1:0] val_rd_o,
  output logic [2:0]      watch_o   // {exec, load, store}
);

  localparam int unsigned DMODE_BIT = XLEN - TYPE_W - 1;

  trig_cfg_t       cfg_q, cfg_d;
  logic [XLEN-1:0] val_q;
  logic            locked;

  assign locked = cfg_q.dmode && !dbg_mode_i;

  always_comb begin
    cfg_d        = '0;
    cfg_d.dmode  = wdata_i[DMODE_BIT];
    cfg_d.sel    = wdata_i[F_SELECT];
    cfg_d.action = wdata_i[F_ACTION +: ACTION_W];
    cfg_d.chain  = wdata_i[F_CHAIN];
    cfg_d.match  = wdata_i[F_MATCH +: MATCH_W];
    cfg_d.m      = wdata_i[F_M];
    cfg_d.h      = wdata_i[F_H];
    cfg_d.s      = wdata_i[F_S];
    cfg_d.u      = wdata_i[F_U];
    cfg_d.exec   = wdata_i[F_EXEC];
    cfg_d.store  = wdata_i[F_STORE];
    cfg_d.load   = wdata_i[F_LOAD];
    // execute matching always fires before the instruction
    cfg_d.timing = wdata_i[F_TIMING] && !wdata_i[F_EXEC];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      val_q <= '0;
    end else begin
      if (cfg_we_i && !locked) cfg_q <= cfg_d;
      if (val_we_i && !locked) val_q <= wdata_i;
    end
  end

  always_comb begin
    cfg_rd_o                            = '0;
    cfg_rd_o[XLEN-1 -: TYPE_W]          = TYPE_ADDR_DATA;
    cfg_rd_o[DMODE_BIT]                 = cfg_q.dmode;
    cfg_rd_o[DMODE_BIT-1 -: MASKMAX_W]  = '0;
    cfg_rd_o[F_SELECT]                  = cfg_q.sel;
    cfg_rd_o[F_TIMING]                  = cfg_q.timing;
    cfg_rd_o[F_ACTION +: ACTION_W]      = cfg_q.action;
    cfg_rd_o[F_CHAIN]                   = cfg_q.chain;
    cfg_rd_o[F_MATCH +: MATCH_W]        = cfg_q.match;
    cfg_rd_o[F_M]                       = cfg_q.m;
    cfg_rd_o[F_H]                       = cfg_q.h;
    cfg_rd_o[F_S]                       = cfg_q.s;
    cfg_rd_o[F_U]                       = cfg_q.u;
    cfg_rd_o[F_EXEC]                    = cfg_q.exec;
    cfg_rd_o[F_STORE]                   = cfg_q.store;
    cfg_rd_o[F_LOAD]                    = cfg_q.load;
  end

  assign val_rd_o = val_q;
  assign watch_o  = {cfg_q.exec, cfg_q.load, cfg_q.store};

  p_exec_timing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.exec |-> !cfg_q.timing);

  p_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_we_i || val_we_i) && locked) |=> ($stable(cfg_q) && $stable(val_q)));

  p_dbg_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_we_i && dbg_mode_i) |=> (val_q == $past(wdata_i)));

endmodule

// File: rtl/trig_summary.sv
module trig_summary #(
  parameter int unsigned NUM_TRIG = 4
) (
  input  logic [NUM_TRIG-1:0][2:0] watch_i,
  output logic                     any_exec_o,
  output logic                     any_load_o,
  output logic                     any_store_o
);

  always_comb begin
    any_exec_o  = 1'b0;
    any_load_o  = 1'b0;
    any_store_o = 1'b0;
    for (int i = 0; i < int'(NUM_TRIG); i++) begin
      any_exec_o  = any_exec_o  | watch_i[i][2];
      any_load_o  = any_load_o  | watch_i[i][1];
      any_store_o = any_store_o | watch_i[i][0];
    end
  end

endmodule

// File: rtl/trig_bank.sv
module trig_bank
  import trig_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 4,
  parameter int unsigned XLEN     = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dbg_mode_i,
  input  logic [1:0]      reg_sel_i,
  input  logic            wr_en_i,
  input  logic [XLEN-1:0] wr_data_i,
  output logic [XLEN-1:0] rd_data_o,
  output logic            watch_exec_o,
  output logic            watch_load_o,
  output logic            watch_store_o
);

  localparam int unsigned SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
  localparam logic [SEL_W:0] LIMIT_SEL = (SEL_W+1)'(NUM_TRIG);

  logic [SEL_W-1:0]          sel;
  logic                      sel_ok;
  logic [XLEN-1:0]           cfg_rd [NUM_TRIG];
  logic [XLEN-1:0]           val_rd [NUM_TRIG];
  logic [NUM_TRIG-1:0][2:0]  watch;
  reg_id_e                   reg_id;

  assign reg_id = reg_id_e'(reg_sel_i);
  assign sel_ok = {1'b0, sel} < LIMIT_SEL;

  trig_sel_reg #(
    .NUM_TRIG (NUM_TRIG),
    .XLEN     (XLEN)
  ) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && (reg_id == REG_INDEX)),
    .wdata_i (wr_data_i),
    .sel_o   (sel)
  );

  for (genvar g = 0; g < int'(NUM_TRIG); g++) begin : g_trig
    logic hit;
    assign hit = (sel == SEL_W'(g));

    trig_entry #(
      .XLEN (XLEN)
    ) u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .dbg_mode_i (dbg_mode_i),
      .cfg_we_i   (wr_en_i && hit && (reg_id == REG_CFG)),
      .val_we_i   (wr_en_i && hit && (reg_id == REG_VALUE)),
      .wdata_i    (wr_data_i),
      .cfg_rd_o   (cfg_rd[g]),
      .val_rd_o   (val_rd[g]),
      .watch_o    (watch[g])
    );
  end

  trig_summary #(
    .NUM_TRIG (NUM_TRIG)
  ) u_summary (
    .watch_i     (watch),
    .any_exec_o  (watch_exec_o),
    .any_load_o  (watch_load_o),
    .any_store_o (watch_store_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (reg_id)
      REG_INDEX: rd_data_o = XLEN'(sel);
      REG_CFG:   if (sel_ok) rd_data_o = cfg_rd[sel];
      REG_VALUE: if (sel_ok) rd_data_o = val_rd[sel];
      default:   rd_data_o = '0;
    endcase
  end

  p_aux_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == 2'd3) |-> (rd_data_o == '0));

  p_idle_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(sel) && $stable({watch_exec_o, watch_load_o, watch_store_o})));

  p_type_field_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == 2'd1) |-> (rd_data_o[XLEN-1 -: TYPE_W] == TYPE_ADDR_DATA));

endmodule

// File: tb/trig_bank_tb.sv
module trig_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int XL = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dbg = 1'b0;
  logic [1:0]    rsel = 2'd0;
  logic          we = 1'b0;
  logic [XL-1:0] wdat = '0;
  logic [XL-1:0] rdat;
  logic          w_exec, w_load, w_store;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference model
  logic [XL-1:0] m_cfg [NT];
  logic [XL-1:0] m_val [NT];
  int            m_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_bank #(.NUM_TRIG(NT), .XLEN(XL)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .dbg_mode_i    (dbg),
    .reg_sel_i     (rsel),
    .wr_en_i       (we),
    .wr_data_i     (wdat),
    .rd_data_o     (rdat),
    .watch_exec_o  (w_exec),
    .watch_load_o  (w_load),
    .watch_store_o (w_store)
  );

  function automatic logic [XL-1:0] cfg_expect(logic [XL-1:0] w);
    logic [XL-1:0] r;
    r = w & 32'h080F_FFFF;       // dmode at 27, fields in [19:0]
    r[31:28] = 4'd2;
    if (r[2]) r[18] = 1'b0;
    return r;
  endfunction

  function automatic logic [2:0] watch_expect();
    logic [2:0] r = 3'b000;
    for (int i = 0; i < NT; i++) r |= {m_cfg[i][2], m_cfg[i][0], m_cfg[i][1]};
    return r;
  endfunction

  task automatic check(string req, logic [XL-1:0] act, logic [XL-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sel = 0;
    for (int i = 0; i < NT; i++) begin
      m_cfg[i] = 32'h2000_0000;
      m_val[i] = '0;
    end
  endtask

  task automatic wr(logic [1:0] r, logic [XL-1:0] d);
    @(negedge clk);
    rsel = r; wdat = d; we = 1'b1;
    @(posedge clk);
    case (r)
      2'd0: if (d < NT) m_sel = int'(d);
      2'd1: if (!(m_cfg[m_sel][27] && !dbg)) m_cfg[m_sel] = cfg_expect(d);
      2'd2: if (!(m_cfg[m_sel][27] && !dbg)) m_val[m_sel] = d;
      default: ;
    endcase
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(string req, logic [1:0] r);
    logic [XL-1:0] e;
    rsel = r;
    #1;
    case (r)
      2'd0: e = XL'(m_sel);
      2'd1: e = m_cfg[m_sel];
      2'd2: e = m_val[m_sel];
      default: e = '0;
    endcase
    check(req, rdat, e);
  endtask

  task automatic read_all(string req);
    for (int t = 0; t < NT; t++) begin
      wr(2'd0, XL'(t));
      rd(req, 2'd1);
      rd(req, 2'd2);
      rd(req, 2'd3);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  // R9: summary outputs compared against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) check("R9 watch", XL'({w_exec, w_load, w_store}), XL'(watch_expect()));
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    rd("R2 index", 2'd0);
    check("R2 watch", XL'({w_exec, w_load, w_store}), '0);
    read_all("R2");

    // R1 index guard
    wr(2'd0, 32'd3);          rd("R1 in range", 2'd0);
    wr(2'd0, 32'd4);          rd("R1 at limit", 2'd0);
    wr(2'd0, 32'hFFFF_FFFF);  rd("R1 all ones", 2'd0);
    wr(2'd0, 32'h0000_0101);  rd("R1 high bits", 2'd0);
    wr(2'd0, 32'd1);          rd("R1 back", 2'd0);

    // R3 packing, timing kept without execute
    wr(2'd0, 32'd0);
    wr(2'd1, 32'hF7F4_0002);  rd("R3 timing store", 2'd1);
    wr(2'd1, 32'h0003_F8F9);  rd("R3 fields", 2'd1);
    // R4 execute clears timing
    wr(2'd0, 32'd2);
    wr(2'd1, 32'h0004_0004);  rd("R4 exec timing", 2'd1);
    check("R4 timing bit", XL'(rdat[18]), '0);

    // R5 lock
    wr(2'd0, 32'd1);
    wr(2'd1, 32'hFFFF_FFFF);  rd("R5 claim", 2'd1);
    wr(2'd1, 32'h0000_0000);  rd("R5 cfg locked", 2'd1);
    wr(2'd2, 32'h0000_1234);  rd("R5 value locked", 2'd2);

    // R6 debug mode unlocks
    dbg = 1'b1;
    wr(2'd2, 32'hABCD_0123);  rd("R6 value", 2'd2);
    wr(2'd1, 32'h0000_0001);  rd("R6 release", 2'd1);
    dbg = 1'b0;
    wr(2'd1, 32'h0000_0002);  rd("R6 after release", 2'd1);

    // R7 per-trigger values
    for (int t = 0; t < NT; t++) begin
      wr(2'd0, XL'(t));
      wr(2'd2, 32'h1111_1111 * (t + 1));
    end
    read_all("R7");

    // R8 auxiliary
    wr(2'd0, 32'd2);
    wr(2'd3, 32'hFFFF_FFFF);
    rd("R8 aux", 2'd3);
    rd("R8 index kept", 2'd0);
    read_all("R8");

    // R10 no write without strobe, combinational read
    @(negedge clk);
    rsel = 2'd1; wdat = 32'hFFFF_FFFF; we = 1'b0;
    @(negedge clk);
    rsel = 2'd0; wdat = 32'd0;
    @(negedge clk);
    read_all("R10");
    rsel = 2'd2; #1; check("R10 comb read", rdat, m_val[m_sel]);

    // mixed traffic
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 120; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      dbg = lfsr[5];
      wr(lfsr[1:0], (lfsr[1:0] == 2'd0) ? {29'd0, lfsr[9:7]} : lfsr ^ 32'h5A5A_0F0F);
      rd("R3 mixed", lfsr[12:11]);
    end
    dbg = 1'b0;
    read_all("R5 mixed");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule